// File: doc/BRIEF.md
# Wide Instruction Memory Loader

This block fills a single-port instruction memory whose entries are 128 bits wide. It does not hold the memory. It drives the memory's one write port: enable, entry address and 128-bit data. Two sources feed that port.

The first source is a 32-bit host bus. It supplies an instruction as four quarter writes to consecutive quarter addresses, beginning at an entry boundary. The second source is a burst engine. It reads an external memory 64 bits per cycle, low half first, and commits one full entry every second cycle.

A mode input decides who may use the block. In system mode the host may write quarters or start a burst. In run mode the host is shut out, and only the core may launch a burst to bring in a new code segment.

Top module: `imem_loader`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_we`, `x_rd`, `done` and `h_err` are low.
- R2: In system mode, four host writes whose `h_addr[1:0]` run 0, 1, 2, 3 and whose `h_addr[AW+1:2]` all match produce exactly one memory write. That write happens in the same cycle as the fourth quarter, goes to entry `h_addr[AW+1:2]`, and places quarter n in bits 32n+31 down to 32n. The first three quarters cause no memory write.
- R3: A quarter write out of order is discarded together with the partial word, and `h_err` pulses high for the one following cycle. Out of order means that its quarter index is not the next expected one (a word must open with quarter 0), or that its entry address differs from that of quarter 0. A later word that begins at quarter 0 is accepted normally.
- R4: In the cycle after a burst is accepted, `x_rd` rises. `x_addr` starts at `bs_xaddr` and rises by one every cycle. Each pair of cycles writes entry `bs_iaddr`+k with `{data at the odd address, data at the even address}`, and this write occurs in the second cycle of the pair.
- R5: After `bs_count` entries, `done` pulses for one cycle. That cycle directly follows the last burst write, and in it `x_rd` is already low.
- R6: In system mode `host_start` launches a burst and `core_start` is ignored.
- R7: In run mode `h_wr` has no effect: there is no memory write and no `h_err`. `host_start` is ignored, and `core_start` launches a burst.
- R8: When the fourth host quarter arrives in a cycle in which the burst writes, the burst gets the port. The host entry is then written in the next cycle with the same address and data.
- R9: A start request made while a burst is running is ignored, and so is a start request with `bs_count` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_mode | input | 1 | 1 = run mode, 0 = system mode |
| h_wr | input | 1 | Host quarter write strobe |
| h_addr | input | AW+2 | Host quarter address: entry in the upper bits, quarter in [1:0] |
| h_data | input | 32 | Host quarter data |
| h_err | output | 1 | One-cycle pulse after a rejected quarter |
| host_start | input | 1 | Host burst start request |
| core_start | input | 1 | Core burst start request |
| bs_xaddr | input | XAW | First external 64-bit address of the burst |
| bs_iaddr | input | AW | First instruction entry of the burst |
| bs_count | input | AW+1 | Number of entries to load |
| x_rd | output | 1 | External read strobe, high while the burst runs |
| x_addr | output | XAW | External 64-bit address |
| x_data | input | 64 | External data, valid in the cycle `x_rd` is high |
| done | output | 1 | One-cycle pulse after the last burst entry is written |
| mem_we | output | 1 | Instruction memory write enable |
| mem_addr | output | AW | Instruction memory entry address |
| mem_wdata | output | 128 | Instruction memory write data |

## Verification
Cycles are numbered from the one in which a stimulus is driven:

| Result | Due in |
|---|---|
| Host commit | the cycle of the fourth quarter |
| Deferred host commit | one cycle after the fourth quarter |
| `h_err` | one cycle after the rejected quarter |
| `x_rd` | one cycle after the start request |
| k-th burst write (k from 0) | cycle 2k+2 |
| `done` | cycle 2N+1 for N entries |

The bench drives inputs just after a rising edge and samples on the falling edge of the cycle in which each result is due. A monitor logs every memory write with its cycle number, and the checks compare that log against these exact cycles.

// File: rtl/imem_loader.sv
module imem_loader #(
  parameter int AW  = 13,
  parameter int XAW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_mode,
  input  logic           h_wr,
  input  logic [AW+1:0]  h_addr,
  input  logic [31:0]    h_data,
  output logic           h_err,
  input  logic           host_start,
  input  logic           core_start,
  input  logic [XAW-1:0] bs_xaddr,
  input  logic [AW-1:0]  bs_iaddr,
  input  logic [AW:0]    bs_count,
  output logic           x_rd,
  output logic [XAW-1:0] x_addr,
  input  logic [63:0]    x_data,
  output logic           done,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [127:0]   mem_wdata
);
  localparam int CW = AW + 1;

  logic           busy, half, pend, err_q, done_q;
  logic [1:0]     qcnt;
  logic [AW-1:0]  sa, ia;
  logic [XAW-1:0] xa;
  logic [CW-1:0]  left;
  logic [63:0]    lo;
  logic [95:0]    st;
  logic [31:0]    pq;

  wire [1:0]    q      = h_addr[1:0];
  wire [AW-1:0] wa     = h_addr[AW+1:2];
  wire          hv     = h_wr && !run_mode;
  wire          hmatch = (q == qcnt) && (qcnt == 2'd0 || wa == sa);
  wire          hc     = hv && hmatch && (q == 2'd3);
  wire          bwe    = busy && half;
  wire          go     = !busy && (bs_count != '0) && (run_mode ? core_start : host_start);

  assign x_rd      = busy;
  assign x_addr    = xa;
  assign h_err     = err_q;
  assign done      = done_q;
  assign mem_we    = bwe || pend || hc;
  assign mem_addr  = bwe ? ia : sa;
  assign mem_wdata = bwe ? {x_data, lo} : {(pend ? pq : h_data), st};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt  <= 2'd0;
      sa    <= '0;
      st    <= '0;
      pq    <= '0;
      pend  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      pend  <= 1'b0;
      if (run_mode) begin
        qcnt <= 2'd0;
      end else if (hv) begin
        if (!hmatch) begin
          qcnt  <= 2'd0;
          err_q <= 1'b1;
        end else if (q == 2'd3) begin
          qcnt <= 2'd0;
          if (bwe) begin
            pend <= 1'b1;
            pq   <= h_data;
          end
        end else begin
          st[{q, 5'd0} +: 32] <= h_data;
          qcnt <= qcnt + 2'd1;
          if (q == 2'd0) sa <= wa;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      half   <= 1'b0;
      done_q <= 1'b0;
      xa     <= '0;
      ia     <= '0;
      left   <= '0;
      lo     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        half <= 1'b0;
        xa   <= bs_xaddr;
        ia   <= bs_iaddr;
        left <= bs_count;
      end else if (busy) begin
        xa   <= xa + 1'b1;
        half <= !half;
        if (!half) begin
          lo <= x_data;
        end else begin
          ia   <= ia + 1'b1;
          left <= left - 1'b1;
          if (left == CW'(1)) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module imem_loader_chk #(
  parameter int XAW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_mode,
  input logic           h_wr,
  input logic           h_err,
  input logic           host_start,
  input logic           core_start,
  input logic           x_rd,
  input logic [XAW-1:0] x_addr,
  input logic           done,
  input logic           mem_we
);
  p_xaddr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd && $past(x_rd)) |-> (x_addr == $past(x_addr) + XAW'(1)));

  p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!x_rd && $past(mem_we) && $past(x_rd)));

  p_start_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_rd) |-> ($past(run_mode) ? $past(core_start) : $past(host_start)));

  p_run_host_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && h_wr) |=> !h_err);

  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> ($past(h_wr) && !$past(run_mode)));
endmodule

bind imem_loader imem_loader_chk #(.XAW(XAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .h_wr(h_wr), .h_err(h_err),
  .host_start(host_start), .core_start(core_start), .x_rd(x_rd),
  .x_addr(x_addr), .done(done), .mem_we(mem_we)
);

// File: tb/test_imem_loader.sv
module test_imem_loader;
  localparam int AW = 13;
  localparam int XAW = 24;

  logic clk = 0, rst_n = 0, run_mode = 0;
  logic h_wr = 0, host_start = 0, core_start = 0;
  logic [AW+1:0] h_addr = '0;
  logic [31:0] h_data = '0;
  logic [XAW-1:0] bs_xaddr = '0;
  logic [AW-1:0] bs_iaddr = '0;
  logic [AW:0] bs_count = '0;
  logic [63:0] x_data;
  logic h_err, x_rd, done, mem_we;
  logic [XAW-1:0] x_addr;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_wdata;

  int errors = 0, checks = 0, cyc = 0, lg_n = 0;
  logic [127:0] lg_d [0:63];
  logic [AW-1:0] lg_a [0:63];
  int lg_c [0:63];

  always #4 clk = ~clk;

  function automatic logic [63:0] xm(input logic [XAW-1:0] a);
    return {8'h5A, a, 8'hC3, a};
  endfunction
  assign x_data = xm(x_addr);

  imem_loader #(.AW(AW), .XAW(XAW)) i_imem_loader (.*);

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && mem_we) begin
    lg_d[lg_n % 64] = mem_wdata;
    lg_a[lg_n % 64] = mem_addr;
    lg_c[lg_n % 64] = cyc;
    lg_n = lg_n + 1;
  end

  task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic hw(input logic [AW-1:0] w, input logic [1:0] q, input logic [31:0] d);
    h_wr = 1; h_addr = {w, q}; h_data = d;
    step();
    h_wr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 outputs in reset", {mem_we, x_rd, done, h_err}, 0);
    rst_n = 1;
    step();
    @(negedge clk);
    chk("R1 outputs after reset", {mem_we, x_rd, done, h_err}, 0);
    step();
  endtask

  task automatic t_host_word();
    int b = lg_n, c3;
    hw(13'h123, 2'd0, 32'h1111_0000);
    hw(13'h123, 2'd1, 32'h2222_0001);
    hw(13'h123, 2'd2, 32'h3333_0002);
    c3 = cyc;
    hw(13'h123, 2'd3, 32'h4444_0003);
    step();
    chk("R2 one write per word", lg_n - b, 1);
    chk("R2 entry address", lg_a[b % 64], 13'h123);
    chk("R2 quarter placement", lg_d[b % 64], 128'h4444_0003_3333_0002_2222_0001_1111_0000);
    chk("R2 write in fourth quarter cycle", lg_c[b % 64], c3);
  endtask

  task automatic t_host_bad();
    int b = lg_n;
    hw(13'h005, 2'd0, 32'hA);
    hw(13'h005, 2'd2, 32'hB);
    @(negedge clk);
    chk("R3 error after skipped quarter", h_err, 1);
    step();
    @(negedge clk);
    chk("R3 error is one cycle", h_err, 0);
    step();
    hw(13'h006, 2'd1, 32'hC);
    @(negedge clk);
    chk("R3 error on word not opening at quarter 0", h_err, 1);
    step();
    hw(13'h007, 2'd0, 32'hD);
    hw(13'h008, 2'd1, 32'hE);
    @(negedge clk);
    chk("R3 error on entry address change", h_err, 1);
    step();
    chk("R3 no write from rejected words", lg_n - b, 0);
    hw(13'h009, 2'd0, 32'h10);
    hw(13'h009, 2'd1, 32'h11);
    hw(13'h009, 2'd2, 32'h12);
    hw(13'h009, 2'd3, 32'h13);
    chk("R3 recovery write", lg_n - b, 1);
    chk("R3 recovery data", lg_d[b % 64], {32'h13, 32'h12, 32'h11, 32'h10});
  endtask

  task automatic t_burst(input bit core, input logic [XAW-1:0] xa0,
                         input logic [AW-1:0] ia0, input int n, input bit poke, input string r);
    int b = lg_n, s;
    run_mode = core; bs_xaddr = xa0; bs_iaddr = ia0; bs_count = (AW+1)'(n);
    if (core) core_start = 1; else host_start = 1;
    s = cyc;
    step();
    core_start = 0; host_start = 0;
    for (int i = 1; i <= 2 * n; i++) begin
      if (poke && i == 2) begin
        bs_xaddr = 24'h777777; bs_iaddr = 13'h1FFF; bs_count = 5;
        if (core) core_start = 1; else host_start = 1;
      end
      @(negedge clk);
      chk({r, " x_rd during burst"}, x_rd, 1);
      chk({r, " R4 x_addr sequence"}, x_addr, xa0 + XAW'(i - 1));
      step();
      core_start = 0; host_start = 0;
    end
    @(negedge clk);
    chk({r, " R5 done pulse"}, {done, x_rd}, 2'b10);
    step();
    @(negedge clk);
    chk({r, " R5 done one cycle"}, done, 0);
    step();
    chk({r, " R4 write count"}, lg_n - b, n);
    for (int k = 0; k < n; k++) begin
      chk({r, " R4 entry"}, lg_a[(b + k) % 64], ia0 + AW'(k));
      chk({r, " R4 data"}, lg_d[(b + k) % 64],
          {xm(xa0 + XAW'(2 * k + 1)), xm(xa0 + XAW'(2 * k))});
      chk({r, " R4 write cycle"}, lg_c[(b + k) % 64], s + 2 * k + 2);
    end
    run_mode = 0;
  endtask

  task automatic t_ignored_starts();
    int b = lg_n;
    bs_xaddr = 24'h100; bs_iaddr = 13'h10; bs_count = 2;
    core_start = 1;
    step();
    core_start = 0;
    @(negedge clk);
    chk("R6 core_start ignored in system mode", x_rd, 0);
    step();
    run_mode = 1; host_start = 1;
    step();
    host_start = 0;
    @(negedge clk);
    chk("R7 host_start ignored in run mode", x_rd, 0);
    step();
    run_mode = 0; bs_count = 0; host_start = 1;
    step();
    host_start = 0;
    @(negedge clk);
    chk("R9 zero count ignored", x_rd, 0);
    step();
    run_mode = 1;
    hw(13'h020, 2'd0, 32'h1);
    hw(13'h020, 2'd1, 32'h2);
    hw(13'h020, 2'd2, 32'h3);
    hw(13'h020, 2'd3, 32'h4);
    @(negedge clk);
    chk("R7 host write gives no error in run mode", h_err, 0);
    step();
    run_mode = 0;
    step(); step();
    chk("R6 R7 R9 no writes from ignored requests", lg_n - b, 0);
  endtask

  task automatic t_collision();
    int b = lg_n, s;
    bs_xaddr = 24'h3000; bs_iaddr = 13'h200; bs_count = 2;
    host_start = 1; h_wr = 1; h_addr = {13'h040, 2'd0}; h_data = 32'hC0;
    s = cyc;
    step();
    host_start = 0; h_addr = {13'h040, 2'd1}; h_data = 32'hC1;
    step();
    h_addr = {13'h040, 2'd2}; h_data = 32'hC2;
    step();
    h_wr = 0;
    step();
    h_wr = 1; h_addr = {13'h040, 2'd3}; h_data = 32'hC3;
    step();
    h_wr = 0;
    step(); step();
    chk("R8 three writes", lg_n - b, 3);
    chk("R8 burst keeps port", {lg_a[(b + 1) % 64], 32'(lg_c[(b + 1) % 64])}, {13'h201, 32'(s + 4)});
    chk("R8 host entry deferred one cycle", {lg_a[(b + 2) % 64], 32'(lg_c[(b + 2) % 64])}, {13'h040, 32'(s + 5)});
    chk("R8 deferred data", lg_d[(b + 2) % 64], {32'hC3, 32'hC2, 32'hC1, 32'hC0});
  endtask

  initial begin
    t_reset();
    t_host_word();
    t_host_bad();
    t_burst(0, 24'h00_1000, 13'h0100, 3, 0, "R6 host burst");
    t_burst(1, 24'hAB_CDEF, 13'h1FFE, 2, 0, "R7 core burst");
    t_burst(0, 24'h00_0040, 13'h0300, 3, 1, "R9 restart while busy");
    t_ignored_starts();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule